// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block converts two digitized supply comparator flags into processor reset controls. The first flag reports that the primary supply is under its trip level. While that flag is active, reset is driven. After the flag clears, reset stays asserted until a selectable number of millisecond ticks has passed. The second flag reports that a secondary monitored voltage is under its own trip level. It is forwarded to a fail output with no stretch and no power-up delay.

Both flags come from the analog domain, so they pass through a synchronizer first. A two-bit configuration field selects one of four release delays. The block captures this field each time the hold count restarts, so a write that lands mid-count cannot change a count already in progress. Each edge of either synchronized flag produces a one-cycle event pulse, which a fault register next door uses. Threshold trimming, the comparators themselves and pad drivers are handled outside this block.

Top module: `supply_rst_seq`

## Requirements
- R1: The delay field selects the release delay in ticks: 2'b00 selects D_SEL0 (50 by default), 2'b01 selects D_SEL1 (200), 2'b10 selects D_SEL2 (400) and 2'b11 selects D_SEL3 (800).
- R2: The delay field holds 2'b01 after reset and takes the value of cfg_sel_i on any clock edge where cfg_we_i is high.
- R3: rst_hi_o is 1 while rst is high. It is also 1 no more than 4 clock edges after pri_low_i goes high, and it stays 1 while pri_low_i stays high.
- R4: Ticks that arrive while the primary flag is active are ignored. Once the synchronized flag is clear, rst_hi_o falls on the clock edge after the Nth tick, where N is the selected delay.
- R5: sec_fail_o takes the value of sec_low_i exactly 3 clock edges after a change on that input, with no stretching in either direction.
- R6: rst_n_o is always the complement of rst_hi_o.
- R7: If pri_low_i goes high again during the hold count, the count is discarded, and a full N ticks must follow the next recovery.
- R8: The delay field is captured at reset (as 2'b01) and on every cycle the synchronized primary flag is active. A write during the count takes effect only at the next restart.
- R9: Each rising or falling edge of pri_low_i or sec_low_i gives exactly one one-cycle pulse on pri_evt_o or sec_evt_o, 3 clock edges after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also acts as power-up |
| tick_i | input | 1 | One-cycle millisecond tick |
| pri_low_i | input | 1 | Primary supply below trip (asynchronous) |
| sec_low_i | input | 1 | Secondary voltage below trip (asynchronous) |
| cfg_we_i | input | 1 | Write strobe for the delay field |
| cfg_sel_i | input | 2 | New delay field value |
| rst_hi_o | output | 1 | Active-high processor reset |
| rst_n_o | output | 1 | Active-low processor reset |
| sec_fail_o | output | 1 | Secondary fail, unstretched |
| pri_evt_o | output | 1 | Edge pulse of the primary flag |
| sec_evt_o | output | 1 | Edge pulse of the secondary flag |

## Verification
The hold counter and the captured limit are visible only through the moment rst_hi_o falls. The bench therefore counts ticks one at a time after each recovery. A stale limit, a counter that was not cleared, or a wrong decode shows up as release on the wrong tick, which is a single tick period after the fault takes effect. A fault in the synchronizer or edge logic shifts sec_fail_o or the event pulses by whole cycles. The bench checks those outputs at exact edge offsets, so such a fault appears within three clocks of the stimulus.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

  typedef enum logic [1:0] {
    DLY_SHORT = 2'b00,
    DLY_STD   = 2'b01,
    DLY_LONG  = 2'b10,
    DLY_MAX   = 2'b11
  } dly_sel_e;

  localparam dly_sel_e DLY_DEFAULT = DLY_STD;

  localparam int FLAG_PRI = 0;
  localparam int FLAG_SEC = 1;
  localparam int FLAG_N   = 2;

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/srs_edge_evt.sv
module srs_edge_evt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flag_i,
  output logic [W-1:0] evt_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] evt_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[i] <= 1'b0;
        evt_q[i]  <= 1'b0;
      end else begin
        prev_q[i] <= flag_i[i];
        evt_q[i]  <= flag_i[i] ^ prev_q[i];
      end
    end

    // R9: a level change on the synchronized flag is followed by a pulse
    p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (rst)
      (flag_i[i] != $past(flag_i[i])) |=> evt_q[i]);
  end

  assign evt_o = evt_q;

endmodule

// File: rtl/srs_hold_timer.sv
module srs_hold_timer
  import supply_rst_pkg::*;
#(
  parameter int       D_SEL0  = 50,
  parameter int       D_SEL1  = 200,
  parameter int       D_SEL2  = 400,
  parameter int       D_SEL3  = 800,
  parameter dly_sel_e RST_SEL = DLY_DEFAULT
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick_i,
  input  logic     low_i,
  input  dly_sel_e sel_i,
  output logic     hold_o
);

  localparam int DMAX01 = (D_SEL0 > D_SEL1) ? D_SEL0 : D_SEL1;
  localparam int DMAX23 = (D_SEL2 > D_SEL3) ? D_SEL2 : D_SEL3;
  localparam int DMAX   = (DMAX01 > DMAX23) ? DMAX01 : DMAX23;
  localparam int CNT_W  = $clog2(DMAX + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t sel_to_lim(input dly_sel_e s);
    cnt_t r;
    case (s)
      DLY_SHORT: r = cnt_t'(D_SEL0);
      DLY_STD:   r = cnt_t'(D_SEL1);
      DLY_LONG:  r = cnt_t'(D_SEL2);
      default:   r = cnt_t'(D_SEL3);
    endcase
    return r;
  endfunction

  cnt_t cnt_q;
  cnt_t lim_q;
  logic hold_q;
  logic last_tick;

  assign last_tick = (cnt_q == lim_q - cnt_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
      lim_q  <= sel_to_lim(RST_SEL);
    end else if (low_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
      lim_q  <= sel_to_lim(sel_i);
    end else if (hold_q && tick_i) begin
      if (last_tick) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + cnt_t'(1);
      end
    end
  end

  assign hold_o = hold_q;

  // R3: an active primary flag forces hold on the next edge
  p_hold_while_low_r3: assert property (@(posedge clk) disable iff (rst)
    low_i |=> hold_q);

  // R4: release only on a tick with the flag clear
  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> ($past(tick_i) && !$past(low_i)));

  // R4: the count never reaches the captured limit
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < lim_q);

  // R1: the captured limit is always one of the four encodings
  p_lim_legal_r1: assert property (@(posedge clk) disable iff (rst)
    (lim_q == cnt_t'(D_SEL0)) || (lim_q == cnt_t'(D_SEL1)) ||
    (lim_q == cnt_t'(D_SEL2)) || (lim_q == cnt_t'(D_SEL3)));

endmodule

// File: rtl/supply_rst_seq.sv
module supply_rst_seq
  import supply_rst_pkg::*;
#(
  parameter int D_SEL0      = 50,
  parameter int D_SEL1      = 200,
  parameter int D_SEL2      = 400,
  parameter int D_SEL3      = 800,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       pri_low_i,
  input  logic       sec_low_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_sel_i,
  output logic       rst_hi_o,
  output logic       rst_n_o,
  output logic       sec_fail_o,
  output logic       pri_evt_o,
  output logic       sec_evt_o
);

  logic [FLAG_N-1:0] flags_async;
  logic [FLAG_N-1:0] flags_sync;
  logic [FLAG_N-1:0] flags_evt;
  dly_sel_e          cfg_q;
  logic              hold;
  logic              rst_hi_q;
  logic              rst_n_q;
  logic              sec_q;

  assign flags_async[FLAG_PRI] = pri_low_i;
  assign flags_async[FLAG_SEC] = sec_low_i;

  // R2: delay field register
  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= DLY_DEFAULT;
    else if (cfg_we_i) cfg_q <= dly_sel_e'(cfg_sel_i);
  end

  srs_sync #(
    .W      (FLAG_N),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i (flags_async),
    .sync_o  (flags_sync)
  );

  srs_edge_evt #(
    .W (FLAG_N)
  ) edge_i (
    .clk    (clk),
    .rst    (rst),
    .flag_i (flags_sync),
    .evt_o  (flags_evt)
  );

  srs_hold_timer #(
    .D_SEL0  (D_SEL0),
    .D_SEL1  (D_SEL1),
    .D_SEL2  (D_SEL2),
    .D_SEL3  (D_SEL3),
    .RST_SEL (DLY_DEFAULT)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .low_i  (flags_sync[FLAG_PRI]),
    .sel_i  (cfg_q),
    .hold_o (hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_hi_q <= 1'b1;
      rst_n_q  <= 1'b0;
      sec_q    <= 1'b0;
    end else begin
      rst_hi_q <= hold;
      rst_n_q  <= !hold;
      sec_q    <= flags_sync[FLAG_SEC];
    end
  end

  assign rst_hi_o   = rst_hi_q;
  assign rst_n_o    = rst_n_q;
  assign sec_fail_o = sec_q;
  assign pri_evt_o  = flags_evt[FLAG_PRI];
  assign sec_evt_o  = flags_evt[FLAG_SEC];

  // R6: the two reset outputs never agree
  p_polarity_r6: assert property (@(posedge clk) disable iff (rst)
    rst_n_q != rst_hi_q);

  // R5: no stretching of the secondary fail output
  p_sec_no_stretch_r5: assert property (@(posedge clk) disable iff (rst)
    !flags_sync[FLAG_SEC] |=> !sec_q);

  // R3: the output follows the timer hold without gaps
  p_rst_follows_hold_r3: assert property (@(posedge clk) disable iff (rst)
    hold |=> rst_hi_q);

endmodule

// File: tb/supply_rst_seq_tb_top.sv
module supply_rst_seq_tb_top;

  localparam int D0 = 3;
  localparam int D1 = 5;
  localparam int D2 = 7;
  localparam int D3 = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       pri_low = 1'b0;
  logic       sec_low = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic       rst_hi, rst_n, sec_fail, pri_evt, sec_evt;

  int total = 0;
  int bad = 0;
  int pri_evt_cnt = 0;
  int sec_evt_cnt = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  supply_rst_seq #(
    .D_SEL0 (D0), .D_SEL1 (D1), .D_SEL2 (D2), .D_SEL3 (D3), .SYNC_STAGES (2)
  ) dut_i (
    .clk (clk), .rst (rst), .tick_i (tick), .pri_low_i (pri_low),
    .sec_low_i (sec_low), .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel),
    .rst_hi_o (rst_hi), .rst_n_o (rst_n), .sec_fail_o (sec_fail),
    .pri_evt_o (pri_evt), .sec_evt_o (sec_evt)
  );

  always @(negedge clk) begin
    if (pri_evt) pri_evt_cnt++;
    if (sec_evt) sec_evt_cnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    wait_neg(3);
  endtask

  task automatic write_sel(input logic [1:0] v);
    @(negedge clk) begin cfg_we = 1'b1; cfg_sel = v; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  // Count ticks until reset releases; 0 if it never does within lim
  task automatic measure(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      pulse_tick();
      check("R6 polarity", rst_n, !rst_hi);
      if (!rst_hi) begin n = i; break; end
    end
  endtask

  task automatic bump_low();
    @(negedge clk) pri_low = 1'b1;
    wait_neg(4);
    check("R3 assert on flag", rst_hi, 1);
    check("R6 polarity low", rst_n, 0);
    @(negedge clk) pri_low = 1'b0;
    wait_neg(4);
  endtask

  task automatic t_reset();
    int n;
    wait_neg(3);
    check("R3 reset state rst_hi", rst_hi, 1);
    check("R6 reset state rst_n", rst_n, 0);
    check("R5 reset state sec_fail", sec_fail, 0);
    @(negedge clk) rst = 1'b0;
    wait_neg(4);
    measure(D3 + 3, n);
    check("R2 default select 01", n, D1);
  endtask

  task automatic t_encodings();
    int n;
    for (int s = 0; s < 4; s++) begin
      write_sel(2'(s));
      bump_low();
      measure(D3 + 3, n);
      case (s)
        0: check("R1 select 00", n, D0);
        1: check("R1 select 01", n, D1);
        2: check("R1 select 10", n, D2);
        default: check("R1 select 11", n, D3);
      endcase
    end
  endtask

  task automatic t_ticks_while_low();
    int n;
    int e0;
    write_sel(2'b00);
    e0 = pri_evt_cnt;
    @(negedge clk) pri_low = 1'b1;
    wait_neg(4);
    check("R3 assert within 4 edges", rst_hi, 1);
    for (int i = 0; i < D3 + 2; i++) pulse_tick();
    check("R4 ticks ignored while low", rst_hi, 1);
    @(negedge clk) pri_low = 1'b0;
    wait_neg(4);
    check("R9 two primary edges", pri_evt_cnt - e0, 2);
    measure(D3 + 3, n);
    check("R4 release on Nth tick", n, D0);
  endtask

  task automatic t_restart();
    int n;
    write_sel(2'b01);
    bump_low();
    pulse_tick();
    pulse_tick();
    check("R7 still held mid count", rst_hi, 1);
    bump_low();
    measure(D3 + 3, n);
    check("R7 full count after restart", n, D1);
  endtask

  task automatic t_sel_change();
    int n;
    write_sel(2'b00);
    @(negedge clk) pri_low = 1'b1;
    wait_neg(4);
    write_sel(2'b11);
    wait_neg(2);
    @(negedge clk) pri_low = 1'b0;
    wait_neg(4);
    measure(D3 + 3, n);
    check("R8 write while low applies", n, D3);
    write_sel(2'b00);
    bump_low();
    pulse_tick();
    write_sel(2'b11);
    measure(D3 + 3, n);
    check("R8 write during count ignored", n + 1, D0);
    bump_low();
    measure(D3 + 3, n);
    check("R8 write used at next restart", n, D3);
  endtask

  task automatic t_secondary();
    int e0;
    e0 = sec_evt_cnt;
    @(negedge clk) sec_low = 1'b1;
    wait_neg(2);
    check("R5 not before 3 edges", sec_fail, 0);
    wait_neg(1);
    check("R5 rise after 3 edges", sec_fail, 1);
    check("R9 sec pulse aligned", sec_evt, 1);
    wait_neg(1);
    check("R9 sec pulse one cycle", sec_evt, 0);
    check("R5 independent of reset", rst_hi, 0);
    @(negedge clk) sec_low = 1'b0;
    wait_neg(2);
    check("R5 held before 3 edges", sec_fail, 1);
    wait_neg(1);
    check("R5 fall after 3 edges no stretch", sec_fail, 0);
    wait_neg(2);
    check("R9 two secondary edges", sec_evt_cnt - e0, 2);
  endtask

  initial begin
    t_reset();
    t_encodings();
    t_ticks_while_low();
    t_restart();
    t_sel_change();
    t_secondary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule